// File: doc/BRIEF.md
# Bus-Cycle Breakpoint Match Unit

This block observes each cycle on a processor's internal bus and decides whether that cycle meets a programmed breakpoint condition. The condition has two parts. The first is a compare address with a per-bit ignore mask. The second is three two-bit qualifiers, one for each of the following:

- which unit owns the cycle (the processor or a transfer engine),
- what kind of access it is (instruction fetch or data access),
- which direction it goes (read or write).

When a cycle meets the condition, the block registers a one-cycle hit strobe. On the same edge it starts a trigger output pulse whose width is programmable, and it enters a held break-request state at fixed priority 15.

An acceptance stage compares the held request against the processor's current four-bit interrupt mask level. It raises an acceptance output only when that level is 14 or lower. The processor acknowledges the request to clear it. Software programs the condition through a small write/read register port.

The trigger stage is a finite-state machine with two states:

- `TRG_IDLE`: no pulse is running. A match takes it to `TRG_RUN` (transition *start*) and loads the width counter.
- `TRG_RUN`: the trigger output is high. Another match reloads the counter and stays in `TRG_RUN` (transition *restart*). When the counter reaches zero with no match, it returns to `TRG_IDLE` (transition *expire*). Otherwise it counts down (transition *count*).

The request stage is a finite-state machine with two states:

- `REQ_IDLE`: no request is held. A match moves it to `REQ_HELD` (transition *raise*).
- `REQ_HELD`: the pending output is high. An acknowledge taken while acceptance is high returns it to `REQ_IDLE` (transition *retire*), unless a new match arrives in the same cycle. In every other case it stays in `REQ_HELD` (transition *hold*).

Top module: `bkpt_match_unit`

## Requirements
- R1: A bus address matches when it equals the compare address (register offset 0) on every bit whose ignore-mask bit (register offset 1) is 0. Mask bits set to 1 are not compared.
- R2: The owner qualifier is control bits [1:0] and is compared with `bus_xfer` (0 = processor, 1 = transfer engine). Code 01 accepts the processor only, 10 accepts the transfer engine only, and 11 accepts either.
- R3: The access qualifier is control bits [3:2] and is compared with `bus_data` (0 = instruction fetch, 1 = data access). Code 01 accepts fetches only, 10 accepts data accesses only, and 11 accepts either.
- R4: The direction qualifier is control bits [5:4] and is compared with `bus_write` (0 = read, 1 = write). Code 01 accepts reads only, 10 accepts writes only, and 11 accepts either.
- R5: If any of the three qualifiers is 00, no hit, trigger pulse or held request is produced, even when every other condition matches.
- R6: A matching cycle with `bus_valid` high raises `brk_hit` for exactly one cycle, starting on the clock edge after the cycle is sampled. Cycles with `bus_valid` low never match.
- R7: `trig_out` rises on the same edge as `brk_hit` and stays high for 1, 2, 4 or 8 cycles when the width select (control bits [7:6]) is 00, 01, 10 or 11.
- R8: A match while `trig_out` is still high restarts the width count, so the pulse lasts the full width counted from the newest hit.
- R9: A hit sets `brk_pending` on the same edge. `brk_accept` is high exactly when `brk_pending` is high and `cpu_level` is 14 or lower. An acknowledge sampled while `brk_accept` is high clears `brk_pending` on the next edge.
- R10: While `cpu_level` is 15, the held request is neither accepted nor cleared, and `cpu_ack` has no effect. Acceptance follows as soon as the level drops to 14 or below.
- R11: After reset, all three registers read back as zero and every output is low. A register written at offset 0, 1 or 2 reads back the written value (the control register reads back its 8 bits, zero-extended). Offset 3 reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register offset: 0 compare address, 1 ignore mask, 2 control |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_sel` |
| bus_valid | input | 1 | A bus cycle is present this clock |
| bus_addr | input | 32 | Bus cycle address |
| bus_xfer | input | 1 | Cycle owner: 0 processor, 1 transfer engine |
| bus_data | input | 1 | Access kind: 0 instruction fetch, 1 data access |
| bus_write | input | 1 | Direction: 0 read, 1 write |
| cpu_level | input | 4 | Processor interrupt mask level |
| cpu_ack | input | 1 | Processor acknowledge of the accepted break |
| brk_hit | output | 1 | One-cycle strobe for each matching bus cycle |
| brk_pending | output | 1 | Break request held at priority 15 |
| brk_accept | output | 1 | Held request is acceptable at the current mask level |
| trig_out | output | 1 | Condition-match trigger pulse |

## Verification
The bound checker checks, on every cycle, the relations between the outputs:

- acceptance implies a held request,
- acceptance is never given at mask level 15,
- a held request survives until it is acknowledged while accepted,
- each hit coincides with a rising trigger and a held request,
- invalid cycles and disabled qualifiers never yield a hit.

Only the bench scenarios can show the behaviours that depend on programmed values or on stretches of time:

- the exact address and mask comparison,
- each qualifier code against each bus attribute,
- the length of each trigger pulse and its restart,
- the sequence of a request waiting at level 15 and then retired by an acknowledge.

// File: rtl/bkpt_pkg.sv
`timescale 1ns/1ps
package bkpt_pkg;

    typedef enum logic [1:0] {
        QUAL_OFF    = 2'b00,
        QUAL_FIRST  = 2'b01,
        QUAL_SECOND = 2'b10,
        QUAL_ANY    = 2'b11
    } qual_e;

    typedef struct packed {
        logic [1:0] width_sel;
        qual_e      dir;
        qual_e      kind;
        qual_e      owner;
    } ctrl_t;

    typedef enum logic {
        TRG_IDLE = 1'b0,
        TRG_RUN  = 1'b1
    } trg_state_e;

    typedef enum logic {
        REQ_IDLE = 1'b0,
        REQ_HELD = 1'b1
    } req_state_e;

    localparam logic [1:0] OFS_ADDR = 2'd0;
    localparam logic [1:0] OFS_MASK = 2'd1;
    localparam logic [1:0] OFS_CTRL = 2'd2;

    function automatic logic qual_pass(qual_e q, logic second);
        logic ok;
        unique case (q)
            QUAL_OFF:    ok = 1'b0;
            QUAL_FIRST:  ok = ~second;
            QUAL_SECOND: ok = second;
            QUAL_ANY:    ok = 1'b1;
            default:     ok = 1'b0;
        endcase
        return ok;
    endfunction

endpackage

// File: rtl/bkpt_regs.sv
`timescale 1ns/1ps
module bkpt_regs
    import bkpt_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [1:0]        sel,
    input  logic [ADDR_W-1:0] wdata,
    output logic [ADDR_W-1:0] rdata,
    output logic [ADDR_W-1:0] cmp_addr,
    output logic [ADDR_W-1:0] ign_mask,
    output ctrl_t             ctrl
);

    localparam int CTRL_W = $bits(ctrl_t);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cmp_addr <= '0;
            ign_mask <= '0;
            ctrl     <= '0;
        end else if (we) begin
            unique case (sel)
                OFS_ADDR: cmp_addr <= wdata;
                OFS_MASK: ign_mask <= wdata;
                OFS_CTRL: ctrl     <= ctrl_t'(wdata[CTRL_W-1:0]);
                default:  ;
            endcase
        end
    end

    always_comb begin
        unique case (sel)
            OFS_ADDR: rdata = cmp_addr;
            OFS_MASK: rdata = ign_mask;
            OFS_CTRL: rdata = {{(ADDR_W-CTRL_W){1'b0}}, ctrl};
            default:  rdata = '0;
        endcase
    end

endmodule

// File: rtl/bkpt_compare.sv
`timescale 1ns/1ps
module bkpt_compare
    import bkpt_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] cmp_addr,
    input  logic [ADDR_W-1:0] ign_mask,
    input  ctrl_t             ctrl,
    input  logic              bus_valid,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_xfer,
    input  logic              bus_data,
    input  logic              bus_write,
    output logic              match_now,
    output logic              hit_q
);

    logic addr_ok;
    logic qual_ok;

    always_comb begin
        addr_ok   = ((bus_addr ^ cmp_addr) & ~ign_mask) == '0;
        qual_ok   = qual_pass(ctrl.owner, bus_xfer)
                  & qual_pass(ctrl.kind,  bus_data)
                  & qual_pass(ctrl.dir,   bus_write);
        match_now = bus_valid & addr_ok & qual_ok;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) hit_q <= 1'b0;
        else        hit_q <= match_now;
    end

endmodule

// File: rtl/bkpt_trigger.sv
`timescale 1ns/1ps
module bkpt_trigger
    import bkpt_pkg::*;
#(
    parameter int SEL_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fire,
    input  logic [SEL_W-1:0] width_sel,
    output logic             trig
);

    localparam int MAX_W = 1 << ((1 << SEL_W) - 1);
    localparam int CNT_W = (MAX_W > 1) ? $clog2(MAX_W) : 1;

    trg_state_e       st_q, st_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic [CNT_W-1:0] load_val;

    // width 2**sel cycles: counter holds cycles remaining after the current one
    always_comb load_val = (CNT_W'(1) << width_sel) - CNT_W'(1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q  <= TRG_IDLE;
            cnt_q <= '0;
        end else begin
            st_q  <= st_d;
            cnt_q <= cnt_d;
        end
    end

    always_comb begin
        st_d  = st_q;
        cnt_d = cnt_q;
        unique case (st_q)
            TRG_IDLE: begin
                if (fire) begin
                    st_d  = TRG_RUN;
                    cnt_d = load_val;
                end
            end
            TRG_RUN: begin
                if (fire) begin
                    cnt_d = load_val;
                end else if (cnt_q == '0) begin
                    st_d = TRG_IDLE;
                end else begin
                    cnt_d = cnt_q - CNT_W'(1);
                end
            end
            default: st_d = TRG_IDLE;
        endcase
    end

    always_comb trig = (st_q == TRG_RUN);

endmodule

// File: rtl/bkpt_request.sv
`timescale 1ns/1ps
module bkpt_request
    import bkpt_pkg::*;
#(
    parameter int LVL_W     = 4,
    parameter int BRK_LEVEL = 15
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fire,
    input  logic [LVL_W-1:0] cpu_level,
    input  logic             cpu_ack,
    output logic             pending,
    output logic             accept
);

    localparam logic [LVL_W-1:0] LEVEL = LVL_W'(BRK_LEVEL);

    req_state_e st_q, st_d;
    logic       level_ok;

    always_comb level_ok = (cpu_level < LEVEL);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= REQ_IDLE;
        else        st_q <= st_d;
    end

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            REQ_IDLE: if (fire) st_d = REQ_HELD;
            REQ_HELD: if (level_ok && cpu_ack && !fire) st_d = REQ_IDLE;
            default:  st_d = REQ_IDLE;
        endcase
    end

    always_comb begin
        pending = (st_q == REQ_HELD);
        accept  = pending & level_ok;
    end

endmodule

// File: rtl/bkpt_match_unit.sv
`timescale 1ns/1ps
module bkpt_match_unit
    import bkpt_pkg::*;
#(
    parameter int ADDR_W    = 32,
    parameter int LVL_W     = 4,
    parameter int BRK_LEVEL = 15
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [1:0]        reg_sel,
    input  logic [ADDR_W-1:0] reg_wdata,
    output logic [ADDR_W-1:0] reg_rdata,
    input  logic              bus_valid,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_xfer,
    input  logic              bus_data,
    input  logic              bus_write,
    input  logic [LVL_W-1:0]  cpu_level,
    input  logic              cpu_ack,
    output logic              brk_hit,
    output logic              brk_pending,
    output logic              brk_accept,
    output logic              trig_out
);

    logic [ADDR_W-1:0] cmp_addr;
    logic [ADDR_W-1:0] ign_mask;
    ctrl_t             ctrl;
    logic              match_now;
    logic [7:0]        ctrl_bits;

    always_comb ctrl_bits = ctrl;

    bkpt_regs #(.ADDR_W(ADDR_W)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .we       (reg_we),
        .sel      (reg_sel),
        .wdata    (reg_wdata),
        .rdata    (reg_rdata),
        .cmp_addr (cmp_addr),
        .ign_mask (ign_mask),
        .ctrl     (ctrl)
    );

    bkpt_compare #(.ADDR_W(ADDR_W)) u_cmp (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmp_addr  (cmp_addr),
        .ign_mask  (ign_mask),
        .ctrl      (ctrl),
        .bus_valid (bus_valid),
        .bus_addr  (bus_addr),
        .bus_xfer  (bus_xfer),
        .bus_data  (bus_data),
        .bus_write (bus_write),
        .match_now (match_now),
        .hit_q     (brk_hit)
    );

    bkpt_trigger #(.SEL_W(2)) u_trg (
        .clk       (clk),
        .rst_n     (rst_n),
        .fire      (match_now),
        .width_sel (ctrl.width_sel),
        .trig      (trig_out)
    );

    bkpt_request #(.LVL_W(LVL_W), .BRK_LEVEL(BRK_LEVEL)) u_req (
        .clk       (clk),
        .rst_n     (rst_n),
        .fire      (match_now),
        .cpu_level (cpu_level),
        .cpu_ack   (cpu_ack),
        .pending   (brk_pending),
        .accept    (brk_accept)
    );

endmodule

// File: rtl/bkpt_match_unit_chk.sv
`timescale 1ns/1ps
module bkpt_match_unit_chk #(
    parameter int LVL_W = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             bus_valid,
    input logic [7:0]       cfg,
    input logic [LVL_W-1:0] cpu_level,
    input logic             cpu_ack,
    input logic             brk_hit,
    input logic             brk_pending,
    input logic             brk_accept,
    input logic             trig_out
);

    localparam logic [LVL_W-1:0] TOP_LEVEL = '1;

    p_accept_needs_pending_r9: assert property (@(posedge clk) disable iff (!rst_n)
        brk_accept |-> brk_pending);

    p_hit_sets_pending_r9: assert property (@(posedge clk) disable iff (!rst_n)
        brk_hit |-> brk_pending);

    p_no_accept_at_top_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_level == TOP_LEVEL) |-> !brk_accept);

    p_pending_held_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (brk_pending && !(brk_accept && cpu_ack)) |=> brk_pending);

    p_hit_with_trigger_r7: assert property (@(posedge clk) disable iff (!rst_n)
        brk_hit |-> trig_out);

    p_invalid_no_hit_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_valid |=> !brk_hit);

    p_qual_off_no_hit_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ((cfg[1:0] == 2'b00) || (cfg[3:2] == 2'b00) || (cfg[5:4] == 2'b00)) |=> !brk_hit);

endmodule

bind bkpt_match_unit bkpt_match_unit_chk #(.LVL_W(LVL_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .bus_valid   (bus_valid),
    .cfg         (ctrl_bits),
    .cpu_level   (cpu_level),
    .cpu_ack     (cpu_ack),
    .brk_hit     (brk_hit),
    .brk_pending (brk_pending),
    .brk_accept  (brk_accept),
    .trig_out    (trig_out)
);

// File: tb/bkpt_match_unit_tb.sv
`timescale 1ns/1ps
module bkpt_match_unit_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [1:0]  reg_sel = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        bus_valid = 1'b0;
    logic [31:0] bus_addr = '0;
    logic        bus_xfer = 1'b0;
    logic        bus_data = 1'b0;
    logic        bus_write = 1'b0;
    logic [3:0]  cpu_level = '0;
    logic        cpu_ack = 1'b0;
    logic        brk_hit, brk_pending, brk_accept, trig_out;

    int checks = 0;
    int failures = 0;
    logic [31:0] m_addr = '0, m_mask = '0;
    logic [7:0]  m_ctrl = '0;

    always #2.5 clk = ~clk;

    bkpt_match_unit u_dut (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .bus_valid(bus_valid),
        .bus_addr(bus_addr), .bus_xfer(bus_xfer), .bus_data(bus_data),
        .bus_write(bus_write), .cpu_level(cpu_level), .cpu_ack(cpu_ack),
        .brk_hit(brk_hit), .brk_pending(brk_pending), .brk_accept(brk_accept),
        .trig_out(trig_out)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic bit q_ok(input logic [1:0] q, input logic b);
        return (q == 2'b11) || (q == 2'b01 && !b) || (q == 2'b10 && b);
    endfunction

    function automatic bit exp_match(input logic [31:0] a, input logic x, input logic d, input logic w);
        return (((a ^ m_addr) & ~m_mask) == 0) && q_ok(m_ctrl[1:0], x)
            && q_ok(m_ctrl[3:2], d) && q_ok(m_ctrl[5:4], w);
    endfunction

    task automatic wr(input logic [1:0] s, input logic [31:0] v);
        @(negedge clk);
        reg_we = 1'b1; reg_sel = s; reg_wdata = v;
        @(negedge clk);
        reg_we = 1'b0;
        if (s == 2'd0) m_addr = v;
        if (s == 2'd1) m_mask = v;
        if (s == 2'd2) m_ctrl = v[7:0];
    endtask

    // drives one cycle; returns at the negedge after the sampling edge
    task automatic bus_cycle(input logic [31:0] a, input logic x, input logic d, input logic w);
        @(negedge clk);
        bus_valid = 1'b1; bus_addr = a; bus_xfer = x; bus_data = d; bus_write = w;
        @(negedge clk);
        bus_valid = 1'b0;
    endtask

    task automatic clear_req;
        @(negedge clk);
        cpu_level = 4'd0; cpu_ack = 1'b1;
        @(negedge clk);
        cpu_ack = 1'b0;
        repeat (10) @(negedge clk);
    endtask

    task automatic t_reset;
        check(!brk_hit && !brk_pending && !brk_accept && !trig_out, "R11", "outputs after reset",
              {brk_hit, brk_pending, brk_accept, trig_out}, 0);
        for (int s = 0; s < 4; s++) begin
            reg_sel = s[1:0]; #1;
            check(reg_rdata == 0, "R11", "register after reset", reg_rdata, 0);
        end
    endtask

    task automatic t_regs;
        wr(2'd0, 32'hCAFE_1234); wr(2'd1, 32'h0000_FF00); wr(2'd2, 32'hFFFF_FFD5);
        @(negedge clk);
        reg_sel = 2'd0; #1; check(reg_rdata == 32'hCAFE_1234, "R11", "addr readback", reg_rdata, 32'hCAFE_1234);
        reg_sel = 2'd1; #1; check(reg_rdata == 32'h0000_FF00, "R11", "mask readback", reg_rdata, 32'h0000_FF00);
        reg_sel = 2'd2; #1; check(reg_rdata == 32'h0000_00D5, "R11", "ctrl readback", reg_rdata, 32'hD5);
        reg_sel = 2'd3; #1; check(reg_rdata == 0, "R11", "offset 3 reads zero", reg_rdata, 0);
    endtask

    task automatic t_addr_mask;
        wr(2'd0, 32'h1000_00F0); wr(2'd1, 32'h0000_000F); wr(2'd2, 32'h0000_003F);
        bus_cycle(32'h1000_00F7, 0, 0, 0);
        check(brk_hit == 1, "R1", "masked low bits ignored", brk_hit, 1);
        bus_cycle(32'h1000_01F0, 0, 0, 0);
        check(brk_hit == 0, "R1", "unmasked bit differs", brk_hit, 0);
        bus_cycle(32'h9000_00F0, 0, 0, 0);
        check(brk_hit == 0, "R1", "top bit differs", brk_hit, 0);
        clear_req();
    endtask

    task automatic t_qualifiers;
        wr(2'd1, 32'h0); wr(2'd0, 32'h0000_4000);
        for (int g = 0; g < 3; g++) begin
            for (int code = 1; code < 4; code++) begin
                logic [7:0] c;
                c = 8'h3F;
                c[2*g +: 2] = code[1:0];
                wr(2'd2, {24'h0, c});
                for (int b = 0; b < 2; b++) begin
                    bit e;
                    logic x, d, w;
                    x = (g == 0) ? b[0] : 1'b0;
                    d = (g == 1) ? b[0] : 1'b0;
                    w = (g == 2) ? b[0] : 1'b0;
                    e = exp_match(32'h0000_4000, x, d, w);
                    bus_cycle(32'h0000_4000, x, d, w);
                    if (g == 0) check(brk_hit == e, "R2", "owner qualifier", brk_hit, e);
                    if (g == 1) check(brk_hit == e, "R3", "access qualifier", brk_hit, e);
                    if (g == 2) check(brk_hit == e, "R4", "direction qualifier", brk_hit, e);
                end
            end
        end
        clear_req();
    endtask

    task automatic t_zero_groups;
        wr(2'd0, 32'h0000_8000); wr(2'd1, 32'h0);
        for (int g = 0; g < 3; g++) begin
            logic [7:0] c;
            c = 8'h3F;
            c[2*g +: 2] = 2'b00;
            wr(2'd2, {24'h0, c});
            bus_cycle(32'h0000_8000, 1, 1, 1);
            check(!brk_hit && !trig_out && !brk_pending, "R5", "disabled qualifier blocks break",
                  {brk_hit, trig_out, brk_pending}, 0);
        end
    endtask

    task automatic t_valid_and_strobe;
        wr(2'd0, 32'h0000_8000); wr(2'd1, 32'h0); wr(2'd2, 32'h0000_003F);
        @(negedge clk);
        bus_valid = 1'b0; bus_addr = 32'h0000_8000;
        @(negedge clk);
        check(brk_hit == 0, "R6", "invalid cycle ignored", brk_hit, 0);
        bus_cycle(32'h0000_8000, 0, 1, 0);
        check(brk_hit == 1, "R6", "hit one edge after cycle", brk_hit, 1);
        @(negedge clk);
        check(brk_hit == 0, "R6", "hit lasts one cycle", brk_hit, 0);
        clear_req();
    endtask

    task automatic t_trig_width;
        wr(2'd0, 32'h0000_0100); wr(2'd1, 32'h0);
        for (int s = 0; s < 4; s++) begin
            int n;
            wr(2'd2, 32'h3F | (s << 6));
            bus_cycle(32'h0000_0100, 0, 0, 1);
            check(trig_out == 1 && brk_hit == 1, "R7", "trigger starts with hit", {trig_out, brk_hit}, 3);
            n = 0;
            while (trig_out && n < 20) begin n++; @(negedge clk); end
            check(n == (1 << s), "R7", "trigger width", n, 1 << s);
        end
        clear_req();
    endtask

    task automatic t_retrigger;
        int n;
        wr(2'd2, 32'h0000_00FF);
        @(negedge clk);
        bus_valid = 1'b1; bus_addr = 32'h0000_0100;
        @(negedge clk);
        bus_valid = 1'b0; n = trig_out ? 1 : 0;
        @(negedge clk);
        if (trig_out) n++;
        bus_valid = 1'b1;
        @(negedge clk);
        bus_valid = 1'b0;
        while (trig_out && n < 30) begin n++; @(negedge clk); end
        check(n == 10, "R8", "retrigger restarts width", n, 10);
        clear_req();
    endtask

    task automatic t_pending;
        wr(2'd0, 32'h0000_0200); wr(2'd1, 32'h0); wr(2'd2, 32'h0000_003F);
        @(negedge clk); cpu_level = 4'd15;
        bus_cycle(32'h0000_0200, 0, 0, 0);
        check(brk_pending == 1 && brk_accept == 0, "R10", "held at level 15", {brk_pending, brk_accept}, 2);
        cpu_ack = 1'b1;
        repeat (3) @(negedge clk);
        cpu_ack = 1'b0;
        check(brk_pending == 1, "R10", "ack ignored at level 15", brk_pending, 1);
        cpu_level = 4'd14; #1;
        check(brk_accept == 1, "R9", "accepted at level 14", brk_accept, 1);
        @(negedge clk);
        check(brk_pending == 1, "R9", "held until ack", brk_pending, 1);
        cpu_ack = 1'b1;
        @(negedge clk);
        cpu_ack = 1'b0;
        check(brk_pending == 0 && brk_accept == 0, "R9", "cleared by ack", {brk_pending, brk_accept}, 0);
    endtask

    task automatic t_random;
        for (int i = 0; i < 300; i++) begin
            logic [31:0] a;
            logic x, d, w;
            bit e;
            if (i % 30 == 0) begin
                wr(2'd0, $urandom); wr(2'd1, $urandom | 32'hFFFF_F000);
                wr(2'd2, $urandom & 32'h3F);
            end
            a = (i % 2 == 0) ? (m_addr ^ ($urandom & 32'h0000_0003)) : $urandom;
            x = 1'($urandom); d = 1'($urandom); w = 1'($urandom);
            e = exp_match(a, x, d, w);
            bus_cycle(a, x, d, w);
            check(brk_hit == e, "R1", "randomized cycle vs model (R2 R3 R4)", brk_hit, e);
        end
        clear_req();
    endtask

    bit done = 0;

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++; failures++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_regs();
        t_addr_mask();
        t_qualifiers();
        t_zero_groups();
        t_valid_and_strobe();
        t_trig_width();
        t_retrigger();
        t_pending();
        t_random();
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule